// File: doc/BRIEF.md
# Word-Mark Delimited Field Comparator

This block compares two character fields that sit in a shared character memory. Each field has no explicit length. Both scans begin at a caller-supplied address and move toward lower addresses. The scan ends at the first word mark carried by either field. The result is reported on four indicator flags: equal, unequal, high and low.

A memory word is 7 bits wide. Bit 6 is the word-mark flag and bits 5:0 are the character code. Ordering between two different codes comes from a 64-entry collating table of 6-bit ranks, which is supplied as a parameter. The block drives two read addresses, one per port, and a read enable. The memory is expected to return both words on the clock edge that follows the address. The block issues a new address pair every cycle and cannot stall, so the memory must keep to this fixed one-cycle latency with no back-pressure.

A chained comparison keeps the indicator state left by the previous comparison and accumulates on top of it. A separate feature input decides whether the equal, high and low results are kept at completion. When it is low, only unequal carries information.

Top module: `field_compare`

## Requirements
- R1: After reset, busy, done and all four indicators are low.
- R2: A start accepted while idle and not chained sets equal high and unequal, high and low low, and this is visible in the cycle after the start edge.
- R3: Once a scan is running, one character pair is read and evaluated per cycle, and both addresses step down by one each cycle. For a scan of K pairs, done is high K+1 cycles after the edge that accepted start.
- R4: The scan stops after it evaluates a pair in which either word has bit 6 (the word mark) set. Pairs without a word mark continue the scan.
- R5: When the two 6-bit codes of a pair differ, equal is cleared and unequal is set. High becomes (rank of B > rank of A) and low becomes its inverse. High and low are never both set.
- R6: If the final pair has a word mark on A but none on B, the result is forced to unequal and high set, with equal and low cleared.
- R7: If the feature input is low at completion, equal, high and low are all cleared, and unequal keeps its value.
- R8: A start accepted with chained high leaves all four indicators unchanged by the start.
- R9: The default collating rank of code c is {c[3:0], c[5:4]}, so ordering is by the low four bits first and then by the top two bits.
- R10: An address of 0 steps to MEM_SIZE-1.
- R11: Done is high for exactly one cycle, with busy low in that cycle. At that time the final-address outputs hold one step below the last compared pair, and they keep that value while the block is idle.
- R12: Start is ignored while a scan is running. The running comparison finishes with the same result and final addresses that it would have had without the extra start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a comparison (only accepted when idle) |
| chained | input | 1 | Keep the previous indicators instead of initialising them |
| a_start | input | AW | First (highest) address of field A |
| b_start | input | AW | First (highest) address of field B |
| hle_en | input | 1 | Keep equal/high/low at completion when high |
| mem_rd_en | output | 1 | Read request for both memory ports |
| mem_a_addr | output | AW | Read address, port A |
| mem_b_addr | output | AW | Read address, port B |
| mem_a_rdata | input | 7 | Port A word one cycle after its address: {mark, code} |
| mem_b_rdata | input | 7 | Port B word one cycle after its address: {mark, code} |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| a_final | output | AW | A address after the scan |
| b_final | output | AW | B address after the scan |
| ind_equal | output | 1 | Equal indicator |
| ind_unequal | output | 1 | Unequal indicator |
| ind_high | output | 1 | High indicator |
| ind_low | output | 1 | Low indicator |

## Verification
The hardest situations to reach are a field that wraps through address 0, and a start pulse that arrives in the middle of a multi-character scan. Both depend on where the fields sit in memory and on exactly when start is raised. Directed runs place a field across the zero boundary and raise a second start, with different addresses, one cycle into a six-pair scan. Random runs fill the memory with a narrow code range, so that equal and unequal pairs are both common. They also plant a guaranteed word mark, and they mix chained and feature-disabled comparisons so that accumulated indicator state is carried from one run to the next.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CODE_W = 6;
  localparam int CHAR_W = CODE_W + 1;
  localparam int NCODES = 1 << CODE_W;

  typedef struct packed {
    logic              wm;
    logic [CODE_W-1:0] code;
  } mchar_t;

  typedef struct packed {
    logic eq;
    logic ne;
    logic hi;
    logic lo;
  } ind_t;

  localparam ind_t IND_INIT = '{eq: 1'b1, ne: 1'b0, hi: 1'b0, lo: 1'b0};

  // Default ranking: low four code bits are most significant, top two least.
  function automatic logic [NCODES*CODE_W-1:0] default_collate();
    logic [NCODES*CODE_W-1:0] tbl;
    logic [CODE_W-1:0]        cv;
    tbl = '0;
    for (int c = 0; c < NCODES; c++) begin
      cv = CODE_W'(c);
      tbl[c*CODE_W +: CODE_W] = {cv[3:0], cv[5:4]};
    end
    return tbl;
  endfunction
endpackage

// File: rtl/fcmp_addr_step.sv
module fcmp_addr_step #(
  parameter int MEM_SIZE = 64,
  parameter int AW       = 6
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] TOP = AW'(MEM_SIZE - 1);

  // Downward step with wrap from the bottom of memory to the top.
  assign nxt = (cur == '0) ? TOP : cur - 1'b1;
endmodule

// File: rtl/fcmp_rank.sv
module fcmp_rank
  import fcmp_pkg::*;
#(
  parameter logic [NCODES*CODE_W-1:0] TABLE = default_collate()
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] rank
);
  assign rank = TABLE[code*CODE_W +: CODE_W];
endmodule

// File: rtl/fcmp_judge.sv
module fcmp_judge
  import fcmp_pkg::*;
(
  input  mchar_t            ca,
  input  mchar_t            cb,
  input  logic [CODE_W-1:0] ra,
  input  logic [CODE_W-1:0] rb,
  input  ind_t              cur,
  input  logic              hle,
  output ind_t              nxt,
  output logic              last
);
  logic b_above;
  assign b_above = (rb > ra);

  always_comb begin
    last = ca.wm | cb.wm;
    nxt  = cur;
    if (ca.code != cb.code) begin
      nxt.eq = 1'b0;
      nxt.ne = 1'b1;
      nxt.hi = b_above;
      nxt.lo = ~b_above;
    end
    if (last) begin
      if (ca.wm && !cb.wm) begin
        nxt.eq = 1'b0;
        nxt.lo = 1'b0;
        nxt.ne = 1'b1;
        nxt.hi = 1'b1;
      end
      if (!hle) begin
        nxt.eq = 1'b0;
        nxt.hi = 1'b0;
        nxt.lo = 1'b0;
      end
    end
  end
endmodule

// File: rtl/field_compare.sv
module field_compare
  import fcmp_pkg::*;
#(
  parameter int MEM_SIZE = 64,
  parameter logic [NCODES*CODE_W-1:0] COLLATE = default_collate(),
  localparam int AW = (MEM_SIZE > 1) ? $clog2(MEM_SIZE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chained,
  input  logic [AW-1:0]     a_start,
  input  logic [AW-1:0]     b_start,
  input  logic              hle_en,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_a_addr,
  output logic [AW-1:0]     mem_b_addr,
  input  logic [CHAR_W-1:0] mem_a_rdata,
  input  logic [CHAR_W-1:0] mem_b_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     a_final,
  output logic [AW-1:0]     b_final,
  output logic              ind_equal,
  output logic              ind_unequal,
  output logic              ind_high,
  output logic              ind_low
);
  logic          busy_q, pend_q, done_q;
  logic [AW-1:0] ptr_a, ptr_b, step_a, step_b;
  ind_t          ind_q, ind_nxt;
  mchar_t        ch_a, ch_b;
  logic [CODE_W-1:0] rank_a, rank_b;
  logic          pair_last;

  assign ch_a = mchar_t'(mem_a_rdata);
  assign ch_b = mchar_t'(mem_b_rdata);

  fcmp_addr_step #(.MEM_SIZE(MEM_SIZE), .AW(AW)) u_step_a (.cur(ptr_a), .nxt(step_a));
  fcmp_addr_step #(.MEM_SIZE(MEM_SIZE), .AW(AW)) u_step_b (.cur(ptr_b), .nxt(step_b));

  fcmp_rank #(.TABLE(COLLATE)) u_rank_a (.code(ch_a.code), .rank(rank_a));
  fcmp_rank #(.TABLE(COLLATE)) u_rank_b (.code(ch_b.code), .rank(rank_b));

  fcmp_judge u_judge (
    .ca(ch_a), .cb(ch_b), .ra(rank_a), .rb(rank_b),
    .cur(ind_q), .hle(hle_en), .nxt(ind_nxt), .last(pair_last)
  );

  // Reads overlap evaluation: the address pair for step k+1 goes out
  // while the words for step k are being judged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      ptr_a  <= '0;
      ptr_b  <= '0;
      ind_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          pend_q <= 1'b0;
          ptr_a  <= a_start;
          ptr_b  <= b_start;
          if (!chained) ind_q <= IND_INIT;
        end
      end else if (pend_q && pair_last) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
        done_q <= 1'b1;
        ind_q  <= ind_nxt;
      end else begin
        ptr_a  <= step_a;
        ptr_b  <= step_b;
        pend_q <= 1'b1;
        if (pend_q) ind_q <= ind_nxt;
      end
    end
  end

  assign mem_rd_en   = busy_q;
  assign mem_a_addr  = ptr_a;
  assign mem_b_addr  = ptr_b;
  assign busy        = busy_q;
  assign done        = done_q;
  assign a_final     = ptr_a;
  assign b_final     = ptr_b;
  assign ind_equal   = ind_q.eq;
  assign ind_unequal = ind_q.ne;
  assign ind_high    = ind_q.hi;
  assign ind_low     = ind_q.lo;

  AST_INIT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !chained) |=> (ind_equal && !ind_unequal && !ind_high && !ind_low)); // R2
  AST_CHAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && chained) |=> $stable({ind_equal, ind_unequal, ind_high, ind_low})); // R8
  AST_HIGH_LOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ind_high && ind_low)); // R5
  AST_FEATURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(hle_en)) |-> (!ind_equal && !ind_high && !ind_low)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_FINAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(a_final) && $stable(b_final))); // R11
endmodule

// File: tb/field_compare_test.sv
module field_compare_test;
  localparam int MS = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, chained = 1'b0, hle_en = 1'b1;
  logic [AW-1:0] a_start = '0, b_start = '0;
  logic mem_rd_en, busy, done;
  logic [AW-1:0] mem_a_addr, mem_b_addr, a_final, b_final;
  logic [6:0] mem_a_rdata = '0, mem_b_rdata = '0;
  logic ind_equal, ind_unequal, ind_high, ind_low;

  int tests = 0, fails = 0;
  logic [6:0] mem [MS];
  logic m_eq = 0, m_ne = 0, m_hi = 0, m_lo = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_a_rdata <= mem[mem_a_addr];
      mem_b_rdata <= mem[mem_b_addr];
    end
  end

  field_compare uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chained(chained),
    .a_start(a_start), .b_start(b_start), .hle_en(hle_en),
    .mem_rd_en(mem_rd_en), .mem_a_addr(mem_a_addr), .mem_b_addr(mem_b_addr),
    .mem_a_rdata(mem_a_rdata), .mem_b_rdata(mem_b_rdata),
    .busy(busy), .done(done), .a_final(a_final), .b_final(b_final),
    .ind_equal(ind_equal), .ind_unequal(ind_unequal),
    .ind_high(ind_high), .ind_low(ind_low)
  );

  function automatic logic [5:0] rank_of(input logic [5:0] c);
    return {c[3:0], c[5:4]};
  endfunction

  function automatic logic [AW-1:0] down(input logic [AW-1:0] x);
    return (x == 0) ? AW'(MS - 1) : x - 1'b1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic chn, input logic hle,
                       output int k, output logic [AW-1:0] fa, output logic [AW-1:0] fb);
    logic [6:0] ca, cb;
    if (!chn) begin m_eq = 1; m_ne = 0; m_hi = 0; m_lo = 0; end
    k = 0;
    ca = '0; cb = '0;
    while (k < 2 * MS) begin
      ca = mem[a]; cb = mem[b]; k++;
      if (ca[5:0] != cb[5:0]) begin
        m_eq = 0; m_ne = 1;
        m_hi = rank_of(cb[5:0]) > rank_of(ca[5:0]);
        m_lo = !m_hi;
      end
      a = down(a); b = down(b);
      if (ca[6] || cb[6]) break;
    end
    if (ca[6] && !cb[6]) begin m_eq = 0; m_lo = 0; m_ne = 1; m_hi = 1; end
    if (!hle) begin m_eq = 0; m_hi = 0; m_lo = 0; end
    fa = a; fb = b;
  endtask

  task automatic run(input string tag, input logic [AW-1:0] a, input logic [AW-1:0] b,
                     input logic chn, input logic hle, input logic poke);
    int k, cnt;
    logic got;
    logic [AW-1:0] fa, fb;
    model(a, b, chn, hle, k, fa, fb);
    @(negedge clk);
    start = 1; chained = chn; a_start = a; b_start = b; hle_en = hle;
    @(negedge clk);
    start = 0;
    if (!chn) check({tag, " R2 init"}, {ind_equal, ind_unequal, ind_high, ind_low}, 4'b1000);
    cnt = 0; got = 0;
    while (!got && cnt < 4 * MS) begin
      if (done) got = 1;
      else begin
        if (poke && cnt == 1) begin start = 1; chained = 0; a_start = ~a; b_start = ~b; end
        else start = 0;
        @(negedge clk);
        cnt++;
      end
    end
    start = 0;
    check({tag, " R3 latency"}, cnt, k + 1);
    check({tag, " R5 indicators"}, {ind_equal, ind_unequal, ind_high, ind_low},
          {m_eq, m_ne, m_hi, m_lo});
    check({tag, " R11 final addr"}, {a_final, b_final}, {fa, fb});
    @(negedge clk);
    check({tag, " R11 done pulse"}, done, 0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MS; i++) mem[i] = 7'h00;
  endtask

  task automatic put(input int addr, input logic [5:0] code, input logic wm);
    mem[addr] = {wm, code};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    clear_mem();
    repeat (3) @(negedge clk);
    check("R1 reset state", {busy, done, ind_equal, ind_unequal, ind_high, ind_low}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4: equal fields of three, marks at the same depth
    clear_mem();
    put(20, 6'd5, 0); put(19, 6'd3, 0); put(18, 6'd1, 1);
    put(40, 6'd5, 0); put(39, 6'd3, 0); put(38, 6'd1, 1);
    run("R4 equal", 20, 40, 0, 1, 0);
    check("R4 equal result", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b1000);

    // R5: mismatch in the middle pair
    put(39, 6'd4, 0);
    run("R5 mismatch", 20, 40, 0, 1, 0);
    check("R5 B higher", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b0110);

    // R8: chained equal comparison keeps the previous mismatch
    put(30, 6'd9, 1); put(50, 6'd9, 1);
    run("R8 chained", 30, 50, 1, 1, 0);
    check("R8 kept", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b0110);

    // R7: feature disabled
    run("R7 hle off", 20, 40, 0, 0, 0);
    check("R7 cleared", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b0100);

    // R6: A shorter than B, same codes
    clear_mem();
    put(20, 6'd7, 0); put(19, 6'd7, 1);
    put(40, 6'd7, 0); put(39, 6'd7, 0); put(38, 6'd7, 0); put(37, 6'd7, 1);
    run("R6 short A", 20, 40, 0, 1, 0);
    check("R6 forced high", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b0110);

    // R4: B shorter, no override
    clear_mem();
    put(20, 6'd2, 0); put(19, 6'd2, 0); put(18, 6'd2, 1);
    put(40, 6'd2, 0); put(39, 6'd2, 1);
    run("R4 short B", 20, 40, 0, 1, 0);
    check("R4 short B equal", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b1000);

    // R9: code 0x10 ranks below code 0x01
    clear_mem();
    put(10, 6'h10, 1); put(44, 6'h01, 1);
    run("R9 rank", 10, 44, 0, 1, 0);
    check("R9 order", {ind_equal, ind_unequal, ind_high, ind_low}, 4'b0110);

    // R10: field wrapping through address 0
    clear_mem();
    put(1, 6'd3, 0); put(0, 6'd3, 0); put(63, 6'd3, 0); put(62, 6'd3, 1);
    put(30, 6'd3, 0); put(29, 6'd3, 0); put(28, 6'd3, 0); put(27, 6'd3, 1);
    run("R10 wrap", 1, 30, 0, 1, 0);
    check("R10 final A", a_final, 61);

    // R12: extra start during a six-pair scan
    clear_mem();
    for (int i = 0; i < 6; i++) begin
      put(50 - i, 6'(i + 1), i == 5);
      put(20 - i, 6'(i + 1), i == 5);
    end
    put(18, 6'd0, 0);
    run("R12 ignored start", 50, 20, 0, 1, 1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] ra, rb;
      for (int i = 0; i < MS; i++) mem[i] = {($urandom % 6) == 0, 6'($urandom % 6)};
      ra = AW'($urandom % MS);
      rb = AW'($urandom % MS);
      mem[(ra + MS - 7) % MS][6] = 1'b1;
      run("R3 random", ra, rb, ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 8) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule